// File: doc/BRIEF.md
# DDR SDRAM Initialization Sequencer

This block owns the command pins of a DDR SDRAM from reset until the memory can take ordinary traffic. After reset it keeps the clock enable low and the bus idle. It then waits until the system reports that supplies and clock are stable. It counts out a power-up delay whose cycle count comes from the clock frequency. After that it raises the clock enable and walks the device through its mandatory bring-up steps.

The bring-up order is fixed. The block raises the clock enable together with a NOP, then closes all banks, then turns the DLL on through the extended mode register. Next it writes the base mode register with the DLL-reset bit set and closes all banks again. It then runs a configurable number of refresh cycles. Last, it rewrites the base mode register with the DLL-reset bit cleared. Every gap between commands is a parameter, and the bus carries NOP inside each gap. A separate lock counter starts when the DLL is reset. The ready flag waits for both this counter and the last mode-register gap.

A controller holds its own command path off the bus until `init_done` is high. After that it takes over.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and on the first edges after it, `cke` is 0. The command bus {cs_n,ras_n,cas_n,we_n} is NOP (4'b0111), `ba` and `addr` are zero, and `init_done` is 0.
- R2: While `pwr_stable` has not yet been sampled high, `cke` stays 0 and the bus stays NOP with zero address.
- R3: `cke` rises exactly PWR_CYC = ceil(CLK_KHZ*PWRUP_US/1000) clock edges after the first edge that samples `pwr_stable` high. The bus shows NOP in the cycle where `cke` rises. `cke` then stays high until reset.
- R4: If `pwr_stable` is sampled low during the power-up count, the count restarts from the next edge that samples it high. Once `cke` is high, `pwr_stable` has no effect on any output.
- R5: The non-NOP commands appear in this order, each for one cycle: precharge-all, extended mode set, mode set with A8=1, precharge-all, REFRESH_COUNT auto refreshes, mode set with A8=0.
- R6: Encodings on {cs_n,ras_n,cas_n,we_n}: NOP 0111, PRECHARGE 0010 with addr[10]=1 (all banks), AUTO REFRESH 0001, MODE SET 0000. NOP and AUTO REFRESH carry all-zero `addr` and `ba`.
- R7: Command-to-command spacing in clock cycles is T_CKE after the NOP that raises `cke`, T_RP after a precharge, T_MRD after a mode write, and T_RFC after a refresh.
- R8: The extended mode write uses ba=1 with addr=EMODE_VAL. Both base-register writes use ba=0 with addr=MODE_VAL, except bit 8, which is 1 in the first write and 0 in the second.
- R9: `init_done` rises at max(Ef+T_MRD, Ed+DLL_LOCK_CYC), where Ef and Ed are the edges that put the final mode write and the DLL-reset mode write on the bus. It then stays high, with `cke` high and the bus on NOP.
- R10: Asserting `rst_n` low at any point returns all outputs to the R1 state at once. After release, the full sequence runs again from the wait for `pwr_stable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | High once supplies and clock are stable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Row/column/mode address |
| init_done | output | 1 | Memory ready for normal commands |

## Verification
The hardest case to reach from the ports is the one where the DLL lock count is not the limiting term of R9. With the usual short refresh spacing, the lock count always decides when `init_done` rises, so the mode-register gap term never shows. The bench therefore drives a second instance whose refresh spacing is long enough that the final mode write comes after the lock count has expired. It compares whichever instance it is observing against the same command table. A second hard case is the restart of the power-up count. The bench drops `pwr_stable` for exactly one edge midway through the count and measures the `cke` rise from the later high sample.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } ddr_cmd_e;

   typedef enum logic [2:0] {
      ASEL_ZERO,
      ASEL_PREA,
      ASEL_EMODE,
      ASEL_MODE_RST,
      ASEL_MODE_RUN
   } addr_sel_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PWRUP,
      ST_PREA1,
      ST_EMRS,
      ST_MRS_RST,
      ST_PREA2,
      ST_REF,
      ST_MRS_RUN,
      ST_LOCK,
      ST_DONE
   } init_step_e;

   localparam int A10_POS = 10;
   localparam int A8_POS  = 8;

endpackage

// File: rtl/ddr_init_downcnt.sv
module ddr_init_downcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;
   logic         armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign expired = armed_q && (cnt_q == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
   import ddr_init_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter int PWR_CYC       = 40000,
   parameter int T_CKE         = 2,
   parameter int T_RP          = 3,
   parameter int T_MRD         = 2,
   parameter int T_RFC         = 15,
   parameter int REFRESH_COUNT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_stable,
   input  logic             gap_expired,
   input  logic             lock_expired,
   output logic             gap_load,
   output logic [CNT_W-1:0] gap_val,
   output logic             lock_start,
   output ddr_cmd_e         cmd,
   output addr_sel_e        asel,
   output logic             cke_next,
   output logic             init_done
);

   localparam int RC_W = $clog2(REFRESH_COUNT + 1);

   init_step_e      step_q, step_d;
   logic [RC_W-1:0] refs_q, refs_d;

   always_comb begin
      step_d     = step_q;
      refs_d     = refs_q;
      gap_load   = 1'b0;
      gap_val    = '0;
      lock_start = 1'b0;
      cmd        = CMD_NOP;
      asel       = ASEL_ZERO;
      cke_next   = 1'b1;
      unique case (step_q)
         ST_IDLE: begin
            cke_next = 1'b0;
            if (pwr_stable) begin
               step_d   = ST_PWRUP;
               gap_load = 1'b1;
               gap_val  = CNT_W'(PWR_CYC - 1);
            end
         end
         ST_PWRUP: begin
            cke_next = 1'b0;
            if (!pwr_stable) begin
               step_d = ST_IDLE;
            end else if (gap_expired) begin
               cke_next = 1'b1;
               step_d   = ST_PREA1;
               gap_load = 1'b1;
               gap_val  = CNT_W'(T_CKE - 1);
            end
         end
         ST_PREA1: if (gap_expired) begin
            cmd      = CMD_PRE;
            asel     = ASEL_PREA;
            step_d   = ST_EMRS;
            gap_load = 1'b1;
            gap_val  = CNT_W'(T_RP - 1);
         end
         ST_EMRS: if (gap_expired) begin
            cmd      = CMD_MRS;
            asel     = ASEL_EMODE;
            step_d   = ST_MRS_RST;
            gap_load = 1'b1;
            gap_val  = CNT_W'(T_MRD - 1);
         end
         ST_MRS_RST: if (gap_expired) begin
            cmd        = CMD_MRS;
            asel       = ASEL_MODE_RST;
            lock_start = 1'b1;
            step_d     = ST_PREA2;
            gap_load   = 1'b1;
            gap_val    = CNT_W'(T_MRD - 1);
         end
         ST_PREA2: if (gap_expired) begin
            cmd      = CMD_PRE;
            asel     = ASEL_PREA;
            step_d   = ST_REF;
            gap_load = 1'b1;
            gap_val  = CNT_W'(T_RP - 1);
         end
         ST_REF: if (gap_expired) begin
            cmd      = CMD_REF;
            gap_load = 1'b1;
            gap_val  = CNT_W'(T_RFC - 1);
            refs_d   = refs_q + 1'b1;
            if (refs_q == RC_W'(REFRESH_COUNT - 1)) step_d = ST_MRS_RUN;
         end
         ST_MRS_RUN: if (gap_expired) begin
            cmd      = CMD_MRS;
            asel     = ASEL_MODE_RUN;
            step_d   = ST_LOCK;
            gap_load = 1'b1;
            gap_val  = CNT_W'(T_MRD - 1);
         end
         ST_LOCK: if (gap_expired && lock_expired) step_d = ST_DONE;
         ST_DONE: step_d = ST_DONE;
         default: step_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         refs_q <= '0;
      end else begin
         step_q <= step_d;
         refs_q <= refs_d;
      end
   end

   assign init_done = (step_q == ST_DONE);

endmodule

// File: rtl/ddr_init_bus_drv.sv
module ddr_init_bus_drv
   import ddr_init_pkg::*;
#(
   parameter int               ROW_W       = 13,
   parameter int               BA_W        = 2,
   parameter logic [ROW_W-1:0] MODE_VAL    = 'h062,
   parameter logic [ROW_W-1:0] EMODE_VAL   = 'h000,
   parameter bit               REG_OUTPUTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke_next,
   input  ddr_cmd_e         cmd,
   input  addr_sel_e        asel,
   output logic             cke,
   output logic             cs_n,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr
);

   localparam logic [ROW_W-1:0] ONE_HOT0  = {{(ROW_W-1){1'b0}}, 1'b1};
   localparam logic [ROW_W-1:0] A10_MASK  = ONE_HOT0 << A10_POS;
   localparam logic [ROW_W-1:0] A8_MASK   = ONE_HOT0 << A8_POS;
   localparam logic [ROW_W-1:0] MODE_RST  = MODE_VAL | A8_MASK;
   localparam logic [ROW_W-1:0] MODE_RUN  = MODE_VAL & ~A8_MASK;

   logic [ROW_W-1:0] addr_d;
   logic [BA_W-1:0]  ba_d;

   always_comb begin
      ba_d   = '0;
      addr_d = '0;
      unique case (asel)
         ASEL_PREA:     addr_d = A10_MASK;
         ASEL_EMODE: begin
            addr_d = EMODE_VAL;
            ba_d   = BA_W'(1);
         end
         ASEL_MODE_RST: addr_d = MODE_RST;
         ASEL_MODE_RUN: addr_d = MODE_RUN;
         default:       addr_d = '0;
      endcase
   end

   generate
      if (REG_OUTPUTS) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cke                        <= 1'b0;
               {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
               ba                         <= '0;
               addr                       <= '0;
            end else begin
               cke                        <= cke_next;
               {cs_n, ras_n, cas_n, we_n} <= cmd;
               ba                         <= ba_d;
               addr                       <= addr_d;
            end
         end
      end else begin : g_comb
         assign cke                        = cke_next;
         assign {cs_n, ras_n, cas_n, we_n} = cmd;
         assign ba                         = ba_d;
         assign addr                       = addr_d;
      end
   endgenerate

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int               CLK_KHZ       = 200000,
   parameter int               PWRUP_US      = 200,
   parameter int               T_CKE         = 2,
   parameter int               T_RP          = 3,
   parameter int               T_MRD         = 2,
   parameter int               T_RFC         = 15,
   parameter int               DLL_LOCK_CYC  = 200,
   parameter int               REFRESH_COUNT = 2,
   parameter int               ROW_W         = 13,
   parameter int               BA_W          = 2,
   parameter logic [ROW_W-1:0] MODE_VAL      = 'h062,
   parameter logic [ROW_W-1:0] EMODE_VAL     = 'h000,
   parameter bit               REG_OUTPUTS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_stable,
   output logic             cke,
   output logic             cs_n,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr,
   output logic             init_done
);

   localparam int PWR_CYC = (CLK_KHZ * PWRUP_US + 999) / 1000;
   localparam int MAX_GAP = (T_RFC > T_RP ? T_RFC : T_RP) > T_MRD ?
                            (T_RFC > T_RP ? T_RFC : T_RP) : T_MRD;
   localparam int MAX_CNT = PWR_CYC > MAX_GAP ? (PWR_CYC > T_CKE ? PWR_CYC : T_CKE)
                                              : (MAX_GAP > T_CKE ? MAX_GAP : T_CKE);
   localparam int CNT_W   = $clog2(MAX_CNT) + 1;
   localparam int LOCK_W  = $clog2(DLL_LOCK_CYC) + 1;

   generate
      if (REFRESH_COUNT < 2)          begin : g_bad_refs  $error("REFRESH_COUNT below 2"); end
      if (DLL_LOCK_CYC < 200)         begin : g_bad_lock  $error("DLL_LOCK_CYC below 200"); end
      if (ROW_W < 11)                 begin : g_bad_row   $error("ROW_W must reach bit 10"); end
      if (BA_W < 2)                   begin : g_bad_ba    $error("BA_W below 2"); end
      if (PWR_CYC < 1)                begin : g_bad_pwr   $error("power-up wait is empty"); end
      if (T_CKE < 1 || T_RP < 1 || T_MRD < 1 || T_RFC < 1)
                                      begin : g_bad_gap   $error("gaps must be at least 1"); end
      if (EMODE_VAL[0] != 1'b0)       begin : g_bad_dll   $error("EMODE_VAL must keep DLL on"); end
   endgenerate

   logic             gap_load, gap_expired;
   logic [CNT_W-1:0] gap_val;
   logic             lock_start, lock_expired;
   ddr_cmd_e         cmd;
   addr_sel_e        asel;
   logic             cke_next;

   ddr_init_fsm #(
      .CNT_W         (CNT_W),
      .PWR_CYC       (PWR_CYC),
      .T_CKE         (T_CKE),
      .T_RP          (T_RP),
      .T_MRD         (T_MRD),
      .T_RFC         (T_RFC),
      .REFRESH_COUNT (REFRESH_COUNT)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_stable   (pwr_stable),
      .gap_expired  (gap_expired),
      .lock_expired (lock_expired),
      .gap_load     (gap_load),
      .gap_val      (gap_val),
      .lock_start   (lock_start),
      .cmd          (cmd),
      .asel         (asel),
      .cke_next     (cke_next),
      .init_done    (init_done)
   );

   ddr_init_downcnt #(.W(CNT_W)) u_gap_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .expired  (gap_expired)
   );

   ddr_init_downcnt #(.W(LOCK_W)) u_lock_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lock_start),
      .load_val (LOCK_W'(DLL_LOCK_CYC - 1)),
      .expired  (lock_expired)
   );

   ddr_init_bus_drv #(
      .ROW_W       (ROW_W),
      .BA_W        (BA_W),
      .MODE_VAL    (MODE_VAL),
      .EMODE_VAL   (EMODE_VAL),
      .REG_OUTPUTS (REG_OUTPUTS)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke_next (cke_next),
      .cmd      (cmd),
      .asel     (asel),
      .cke      (cke),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ba       (ba),
      .addr     (addr)
   );

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int DLL_LOCK_CYC  = 200,
   parameter int REFRESH_COUNT = 2,
   parameter int ROW_W         = 13,
   parameter int BA_W          = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             cs_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic [BA_W-1:0]  ba,
   input logic [ROW_W-1:0] addr,
   input logic             init_done
);

   logic [3:0] bus;
   assign bus = {cs_n, ras_n, cas_n, we_n};

   logic        is_nop, is_pre, is_ref, is_mrs;
   assign is_nop = (bus == 4'b0111);
   assign is_pre = (bus == 4'b0010);
   assign is_ref = (bus == 4'b0001);
   assign is_mrs = (bus == 4'b0000);

   logic [31:0] since_q;
   logic        seen_q;
   logic [31:0] refs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
         refs_q  <= '0;
      end else begin
         if (is_mrs && ba == '0 && addr[8]) begin
            since_q <= 32'd1;
            seen_q  <= 1'b1;
         end else if (seen_q && since_q != '1) begin
            since_q <= since_q + 1'b1;
         end
         if (is_ref) refs_q <= refs_q + 1'b1;
      end
   end

   AST_IDLE_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (is_nop && addr == '0 && ba == '0));                          // R2
   AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);                                                          // R3
   AST_CKE_RISE_ON_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> is_nop);                                                // R3
   AST_LEGAL_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
      cke |-> (is_nop || is_pre || is_ref || is_mrs));                       // R6
   AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> addr[10]);                                                  // R6
   AST_QUIET_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_nop || is_ref) |-> (addr == '0 && ba == '0));                      // R6
   AST_MODE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (ba <= BA_W'(1)));                                          // R8
   AST_REFRESH_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (refs_q >= 32'(REFRESH_COUNT)));                  // R5
   AST_DLL_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (seen_q && since_q >= 32'(DLL_LOCK_CYC)));        // R9
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);                                              // R9
   AST_DONE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cke && is_nop));                                        // R9

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
   .DLL_LOCK_CYC  (DLL_LOCK_CYC),
   .REFRESH_COUNT (REFRESH_COUNT),
   .ROW_W         (ROW_W),
   .BA_W          (BA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .init_done (init_done)
);

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_KHZ    = 100;
   localparam int PWRUP_US   = 200;
   localparam int W_CYC      = (CLK_KHZ * PWRUP_US + 999) / 1000;
   localparam int T_CKE      = 2;
   localparam int T_RP       = 3;
   localparam int T_MRD      = 2;
   localparam int T_RFC_A    = 5;
   localparam int T_RFC_B    = 100;
   localparam int LOCK       = 200;
   localparam int N_REF      = 3;
   localparam logic [12:0] MODE  = 13'h0032;
   localparam logic [12:0] EMODE = 13'h0002;

   // dcls: 0 = T_CKE, 1 = T_RP, 2 = T_MRD, 3 = T_RFC (spacing before the entry)
   typedef struct packed {
      logic [3:0]  cmd;
      logic [1:0]  ba;
      logic [12:0] addr;
      logic [1:0]  dcls;
   } entry_t;

   localparam int N_ENT = 9;
   localparam entry_t SEQ [N_ENT] = '{
      '{4'b0111, 2'd0, 13'h0000, 2'd0},
      '{4'b0010, 2'd0, 13'h0400, 2'd0},
      '{4'b0000, 2'd1, EMODE,    2'd1},
      '{4'b0000, 2'd0, 13'h0132, 2'd2},
      '{4'b0010, 2'd0, 13'h0400, 2'd2},
      '{4'b0001, 2'd0, 13'h0000, 2'd1},
      '{4'b0001, 2'd0, 13'h0000, 2'd3},
      '{4'b0001, 2'd0, 13'h0000, 2'd3},
      '{4'b0000, 2'd0, 13'h0032, 2'd3}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic pwr_stable;
   logic sel;

   logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
   logic [1:0]  a_ba;
   logic [12:0] a_addr;
   logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
   logic [1:0]  b_ba;
   logic [12:0] b_addr;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ddr_init_seq #(
      .CLK_KHZ(CLK_KHZ), .PWRUP_US(PWRUP_US), .T_CKE(T_CKE), .T_RP(T_RP),
      .T_MRD(T_MRD), .T_RFC(T_RFC_A), .DLL_LOCK_CYC(LOCK), .REFRESH_COUNT(N_REF),
      .ROW_W(13), .BA_W(2), .MODE_VAL(MODE), .EMODE_VAL(EMODE), .REG_OUTPUTS(1'b1)
   ) u_ddr_init_seq (
      .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
      .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
      .ba(a_ba), .addr(a_addr), .init_done(a_done)
   );

   ddr_init_seq #(
      .CLK_KHZ(CLK_KHZ), .PWRUP_US(PWRUP_US), .T_CKE(T_CKE), .T_RP(T_RP),
      .T_MRD(T_MRD), .T_RFC(T_RFC_B), .DLL_LOCK_CYC(LOCK), .REFRESH_COUNT(N_REF),
      .ROW_W(13), .BA_W(2), .MODE_VAL(MODE), .EMODE_VAL(EMODE), .REG_OUTPUTS(1'b1)
   ) u_ddr_init_seq_slow (
      .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
      .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
      .ba(b_ba), .addr(b_addr), .init_done(b_done)
   );

   logic        o_cke, o_done;
   logic [3:0]  o_bus;
   logic [1:0]  o_ba;
   logic [12:0] o_addr;
   assign o_cke  = sel ? b_cke  : a_cke;
   assign o_done = sel ? b_done : a_done;
   assign o_bus  = sel ? {b_cs, b_ras, b_cas, b_we} : {a_cs, a_ras, a_cas, a_we};
   assign o_ba   = sel ? b_ba   : a_ba;
   assign o_addr = sel ? b_addr : a_addr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cyc++;
   endtask

   function automatic logic [20:0] snap();
      return {o_cke, o_bus, o_ba, o_addr, o_done};
   endfunction

   localparam logic [20:0] IDLE_SNAP = {1'b0, 4'b0111, 2'b00, 13'h0000, 1'b0};
   localparam logic [20:0] DONE_SNAP = {1'b1, 4'b0111, 2'b00, 13'h0000, 1'b1};

   function automatic int spacing(input logic [1:0] dcls);
      case (dcls)
         2'd0:    return T_CKE;
         2'd1:    return T_RP;
         2'd2:    return T_MRD;
         default: return sel ? T_RFC_B : T_RFC_A;
      endcase
   endfunction

   // Called right after the negedge where pwr_stable (or rst_n) was made
   // such that the next posedge is the first one sampling stable high.
   task automatic run_sequence(input string tag);
      bit ok;
      int s_d, s_f, exp_done;
      logic [20:0] bad_snap;
      ok = 1'b1;
      bad_snap = '0;
      for (int k = 1; k <= W_CYC; k++) begin
         tick();
         if (snap() != IDLE_SNAP) begin ok = 1'b0; bad_snap = snap(); end
      end
      check(ok, "R3", {tag, " cke low through power-up wait"}, 32'(bad_snap), 32'(IDLE_SNAP));
      s_d = 0;
      s_f = 0;
      for (int e = 0; e < N_ENT; e++) begin
         int d;
         d  = (e == 0) ? 1 : spacing(SEQ[e].dcls);
         ok = 1'b1;
         for (int i = 1; i < d; i++) begin
            tick();
            if (!(o_cke && o_bus == 4'b0111 && !o_done)) begin ok = 1'b0; bad_snap = snap(); end
         end
         if (d > 1)
            check(ok, "R7", {tag, " NOP gap before step"}, 32'(bad_snap), 32'(e));
         tick();
         check(o_cke && !o_done && o_bus == SEQ[e].cmd && o_ba == SEQ[e].ba &&
               o_addr == SEQ[e].addr,
               (e == 0) ? "R3" : ((e == 3 || e == 8 || e == 2) ? "R8 R5 R7" : "R5 R6 R7"),
               {tag, " command step"},
               32'({o_cke, o_bus, o_ba, o_addr}),
               32'({1'b1, SEQ[e].cmd, SEQ[e].ba, SEQ[e].addr}));
         if (e == 3) s_d = cyc;
         if (e == N_ENT - 1) s_f = cyc;
      end
      exp_done = (s_f + T_MRD > s_d + LOCK) ? s_f + T_MRD : s_d + LOCK;
      ok = 1'b1;
      while (cyc < exp_done - 1) begin
         tick();
         if (!(o_cke && o_bus == 4'b0111 && !o_done)) begin ok = 1'b0; bad_snap = snap(); end
      end
      check(ok, "R9", {tag, " done low and bus quiet before ready point"}, 32'(bad_snap), 32'h0);
      tick();
      check(snap() == DONE_SNAP, "R9", {tag, " done rises at max of lock and MRD gap"},
            32'(snap()), 32'(DONE_SNAP));
      ok = 1'b1;
      for (int i = 0; i < 10; i++) begin
         tick();
         if (snap() != DONE_SNAP) begin ok = 1'b0; bad_snap = snap(); end
      end
      check(ok, "R9", {tag, " done holds"}, 32'(bad_snap), 32'(DONE_SNAP));
   endtask

   initial begin
      bit ok;
      logic [20:0] bad_snap;
      sel        = 1'b0;
      rst_n      = 1'b0;
      pwr_stable = 1'b0;
      repeat (3) tick();
      check(snap() == IDLE_SNAP, "R1", "outputs in reset", 32'(snap()), 32'(IDLE_SNAP));
      rst_n = 1'b1;
      tick();
      check(snap() == IDLE_SNAP, "R1", "first edge after reset", 32'(snap()), 32'(IDLE_SNAP));

      // R2: no stable indication, nothing happens
      ok = 1'b1;
      bad_snap = '0;
      for (int i = 0; i < 3 * W_CYC; i++) begin
         tick();
         if (snap() != IDLE_SNAP) begin ok = 1'b0; bad_snap = snap(); end
      end
      check(ok, "R2", "idle without pwr_stable", 32'(bad_snap), 32'(IDLE_SNAP));

      // Table walk, lock-limited instance
      pwr_stable = 1'b1;
      run_sequence("fast");

      // R4: stable drop after cke high is ignored
      pwr_stable = 1'b0;
      ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tick();
         if (snap() != DONE_SNAP) begin ok = 1'b0; bad_snap = snap(); end
      end
      check(ok, "R4", "pwr_stable drop after ready ignored", 32'(bad_snap), 32'(DONE_SNAP));

      // R10: reset after ready
      rst_n = 1'b0;
      #1;
      check(snap() == IDLE_SNAP, "R10", "async reset clears ready state",
            32'(snap()), 32'(IDLE_SNAP));
      tick();
      rst_n = 1'b1;
      tick();

      // R4: restart of the power-up count
      pwr_stable = 1'b1;
      ok = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick();
         if (snap() != IDLE_SNAP) begin ok = 1'b0; bad_snap = snap(); end
      end
      pwr_stable = 1'b0;
      tick();
      if (snap() != IDLE_SNAP) ok = 1'b0;
      check(ok, "R4", "cke low while count is interrupted", 32'(snap()), 32'(IDLE_SNAP));
      pwr_stable = 1'b1;
      run_sequence("restart");

      // R10: reset in the middle of the command sequence
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      for (int i = 0; i < W_CYC + T_CKE + T_RP; i++) tick();
      check(o_cke == 1'b1, "R10", "sequence under way before mid reset", 32'(o_cke), 32'h1);
      rst_n = 1'b0;
      #1;
      check(snap() == IDLE_SNAP, "R10", "mid-sequence reset", 32'(snap()), 32'(IDLE_SNAP));
      tick();
      rst_n = 1'b1;
      run_sequence("after mid reset");

      // Refresh-spacing-limited instance
      rst_n = 1'b0;
      tick();
      sel   = 1'b1;
      #1;
      check(snap() == IDLE_SNAP, "R1", "slow instance in reset", 32'(snap()), 32'(IDLE_SNAP));
      tick();
      rst_n = 1'b1;
      run_sequence("slow");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule